// File: doc/BRIEF.md
# Eager-Forward Flit Validity Checker

This block sits at one input of a mesh switch whose outputs forward flits speculatively along preconfigured preferred paths. A flit can reach this input over such a path before any routing decision has been made for it. The checker judges each arriving flit against the local node coordinates and the side it came in from. It then decides one of three things. The flit may travel on along the preferred path. It may need to be written into the local input FIFO so that normal routing can handle it. Or it may be a dead copy that is carried to the end of the preferred path and discarded there.

Buffered flits follow dimension-ordered XY routing: first along X until the column matches, then along Y. The checker computes that output direction for every valid flit. It also watches the occupancy of the input FIFO. Once the FIFO is almost full, it tells the upstream output feeding this input to hold off. While that condition lasts, flits that arrive by preferred path are written into the FIFO in addition to being passed on. Decisions are registered and appear one clock cycle after the flit is presented.

Top module: `eager_flit_checker`

## Requirements
- R1: For a valid flit, `dec_dir` one cycle later gives the XY direction. The X axis is resolved first. Encoding: 0 local, 1 north (+y), 2 east (+x), 3 south (-y), 4 west (-x).
- R2: A flit that arrived eagerly (`in_eager`=1) from a neighbour counts as correct when its last hop reduced its distance to the destination on X or on Y. The hop is inferred from `in_from`, which uses the same encoding as R1 and names the side the flit entered from. A flit entering from side 0 (local) is always correct.
- R3: An eager flit that is not correct is marked dead (`dec_dead`=1) and is never written into the FIFO (`dec_enq`=0).
- R4: A dead flit gets `dec_kind`=1 (pass) while `pref_on`=1, because it rides on to the end of the preferred path. When `pref_on`=0 it gets `dec_kind`=3 (drop).
- R5: A correct eager flit whose XY direction equals `pref_dir` while `pref_on`=1 gets `dec_kind`=1. It is not written into the FIFO unless R9 applies.
- R6: Any other valid flit, whether non-eager or correct with a direction mismatch, gets `dec_kind`=2 (enqueue) with `dec_enq`=1.
- R7: A flit whose destination equals the node coordinates is never dead, and its `dec_dir` is 0.
- R8: Almost-full means `fifo_count` >= DEPTH-1. `up_stall` shows that condition one cycle later.
- R9: While almost-full holds, a flit passed under R5 is also written into the FIFO (`dec_enq`=1).
- R10: In a cycle with `in_valid`=0, and after reset, the next outputs are `dec_kind`=0, `dec_enq`=0, `dec_dead`=0, `dec_dir`=0. Reset also clears `up_stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A flit is present this cycle |
| in_dst_x | input | XW | Destination column of the flit |
| in_dst_y | input | YW | Destination row of the flit |
| in_from | input | 3 | Side the flit entered from |
| in_eager | input | 1 | Flit arrived over an upstream preferred path |
| node_x | input | XW | Local column |
| node_y | input | YW | Local row |
| pref_on | input | 1 | The preferred path continues through this input |
| pref_dir | input | 3 | Output the preferred path continues to |
| fifo_count | input | CW | Current occupancy of the input FIFO |
| dec_kind | output | 2 | 0 idle, 1 pass, 2 enqueue, 3 drop |
| dec_dir | output | 3 | XY direction of the decided flit |
| dec_enq | output | 1 | Write the flit into the input FIFO |
| dec_dead | output | 1 | Flit is a dead copy |
| up_stall | output | 1 | Backpressure toward the upstream output |

## Verification
The interesting overlap is a correct preferred-path flit arriving while the FIFO reports almost full. In that cycle the pass decision and the backpressure-forced write both apply, and `up_stall` rises together with the pass. The bench provokes this by sweeping `fifo_count` over every level for every combination of arrival side, destination, eagerness and preferred direction. It judges the result against an independent distance-based model. That model expects both `dec_kind`=1 and `dec_enq`=1, and the stall flag derived from the same count. Dead flits in the same almost-full cycles must still show no write.

// File: rtl/efc_pkg.sv
package efc_pkg;
  localparam int CW_MAX = 16;

  typedef enum logic [2:0] {
    DIR_LOCAL = 3'd0,
    DIR_NORTH = 3'd1,
    DIR_EAST  = 3'd2,
    DIR_SOUTH = 3'd3,
    DIR_WEST  = 3'd4
  } dir_e;

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_PASS = 2'd1,
    K_ENQ  = 2'd2,
    K_DROP = 2'd3
  } kind_e;

  // dimension-ordered step: resolve the column first, then the row
  function automatic dir_e xy_step(input logic [CW_MAX-1:0] nx, input logic [CW_MAX-1:0] ny,
                                   input logic [CW_MAX-1:0] dx, input logic [CW_MAX-1:0] dy);
    if (dx > nx) return DIR_EAST;
    if (dx < nx) return DIR_WEST;
    if (dy > ny) return DIR_NORTH;
    if (dy < ny) return DIR_SOUTH;
    return DIR_LOCAL;
  endfunction

  // a hop along one axis only changes that axis; it helped when the
  // destination is not behind the current node along the travel direction
  function automatic logic hop_helped(input dir_e from,
                                      input logic [CW_MAX-1:0] nx, input logic [CW_MAX-1:0] ny,
                                      input logic [CW_MAX-1:0] dx, input logic [CW_MAX-1:0] dy);
    case (from)
      DIR_WEST:  return dx >= nx;
      DIR_EAST:  return dx <= nx;
      DIR_SOUTH: return dy >= ny;
      DIR_NORTH: return dy <= ny;
      default:   return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/efc_route_unit.sv
module efc_route_unit
  import efc_pkg::*;
#(
  parameter int XW = 2,
  parameter int YW = 2
) (
  input  logic [XW-1:0] node_x,
  input  logic [YW-1:0] node_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  output dir_e          route_dir,
  output logic          at_home
);
  logic [CW_MAX-1:0] nx_w, ny_w, dx_w, dy_w;

  assign nx_w = CW_MAX'(node_x);
  assign ny_w = CW_MAX'(node_y);
  assign dx_w = CW_MAX'(dst_x);
  assign dy_w = CW_MAX'(dst_y);

  assign route_dir = xy_step(nx_w, ny_w, dx_w, dy_w);
  assign at_home   = (dst_x == node_x) && (dst_y == node_y);
endmodule

// File: rtl/efc_progress_unit.sv
module efc_progress_unit
  import efc_pkg::*;
#(
  parameter int XW = 2,
  parameter int YW = 2
) (
  input  dir_e          from_dir,
  input  logic [XW-1:0] node_x,
  input  logic [YW-1:0] node_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  output logic          progress
);
  assign progress = hop_helped(from_dir, CW_MAX'(node_x), CW_MAX'(node_y),
                               CW_MAX'(dst_x), CW_MAX'(dst_y));
endmodule

// File: rtl/efc_fill_watch.sv
module efc_fill_watch #(
  parameter int DEPTH = 2,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] fifo_count,
  output logic          almost_full,
  output logic          up_stall
);
  localparam logic [CW-1:0] AF_LEVEL = CW'(DEPTH - 1);

  assign almost_full = fifo_count >= AF_LEVEL;

  always_ff @(posedge clk) begin
    if (!rst_n) up_stall <= 1'b0;
    else        up_stall <= almost_full;
  end

  // R8: one free slot left raises the stall on the next edge
  a_r8_warn_next: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count >= AF_LEVEL) |=> up_stall);
  a_r8_quiet_next: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count < AF_LEVEL) |=> !up_stall);
endmodule

// File: rtl/eager_flit_checker.sv
module eager_flit_checker
  import efc_pkg::*;
#(
  parameter int XW    = 2,
  parameter int YW    = 2,
  parameter int DEPTH = 2,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [XW-1:0] in_dst_x,
  input  logic [YW-1:0] in_dst_y,
  input  logic [2:0]    in_from,
  input  logic          in_eager,
  input  logic [XW-1:0] node_x,
  input  logic [YW-1:0] node_y,
  input  logic          pref_on,
  input  logic [2:0]    pref_dir,
  input  logic [CW-1:0] fifo_count,
  output logic [1:0]    dec_kind,
  output logic [2:0]    dec_dir,
  output logic          dec_enq,
  output logic          dec_dead,
  output logic          up_stall
);
  dir_e  route;
  logic  at_home;
  logic  progress;
  logic  almost_full;

  // named events for the checks below
  logic  ev_dead;
  logic  ev_pass_hit;
  logic  ev_forced_enq;

  kind_e nxt_kind;
  logic  nxt_enq;

  efc_route_unit #(.XW(XW), .YW(YW)) u_route (
    .node_x(node_x), .node_y(node_y), .dst_x(in_dst_x), .dst_y(in_dst_y),
    .route_dir(route), .at_home(at_home)
  );

  efc_progress_unit #(.XW(XW), .YW(YW)) u_prog (
    .from_dir(dir_e'(in_from)), .node_x(node_x), .node_y(node_y),
    .dst_x(in_dst_x), .dst_y(in_dst_y), .progress(progress)
  );

  efc_fill_watch #(.DEPTH(DEPTH), .CW(CW)) u_fill (
    .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count),
    .almost_full(almost_full), .up_stall(up_stall)
  );

  assign ev_dead       = in_valid && in_eager && !progress;
  assign ev_pass_hit   = in_valid && in_eager && progress && pref_on && (dir_e'(pref_dir) == route);
  assign ev_forced_enq = ev_pass_hit && almost_full;

  always_comb begin
    nxt_kind = K_IDLE;
    nxt_enq  = 1'b0;
    if (in_valid) begin
      if (ev_dead) begin
        nxt_kind = pref_on ? K_PASS : K_DROP;
      end else if (ev_pass_hit) begin
        nxt_kind = K_PASS;
        nxt_enq  = ev_forced_enq;
      end else begin
        nxt_kind = K_ENQ;
        nxt_enq  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_kind <= K_IDLE;
      dec_dir  <= DIR_LOCAL;
      dec_enq  <= 1'b0;
      dec_dead <= 1'b0;
    end else begin
      dec_kind <= nxt_kind;
      dec_dir  <= in_valid ? route : DIR_LOCAL;
      dec_enq  <= nxt_enq;
      dec_dead <= ev_dead;
    end
  end

  // R3: a dead copy is never written
  a_r3_dead_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
    dec_dead |-> !dec_enq);
  // R4: a drop verdict only for dead copies
  a_r4_drop_is_dead: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_kind == K_DROP) |-> dec_dead);
  // R7: a flit at its destination stays alive and ejects locally
  a_r7_home_alive: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && at_home) |=> (!dec_dead && dec_dir == DIR_LOCAL));
  // R9: preferred-path pass under almost-full also writes the FIFO
  a_r9_pass_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pass_hit && almost_full) |=> (dec_enq && dec_kind == K_PASS));
  // R10: an empty cycle leaves an idle verdict
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (dec_kind == K_IDLE && !dec_enq && !dec_dead));
  // R1: direction code stays inside the five legal sides
  a_r1_dir_legal: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (dec_dir <= 3'd4));
endmodule

// File: tb/eager_flit_checker_tb.sv
`timescale 1ns/1ps
module eager_flit_checker_tb;
  localparam int XW = 2, YW = 2, DEPTH = 2, CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [XW-1:0] in_dst_x = '0;
  logic [YW-1:0] in_dst_y = '0;
  logic [2:0] in_from = '0;
  logic in_eager = 1'b0;
  logic [XW-1:0] node_x = '0;
  logic [YW-1:0] node_y = '0;
  logic pref_on = 1'b0;
  logic [2:0] pref_dir = '0;
  logic [CW-1:0] fifo_count = '0;
  logic [1:0] dec_kind;
  logic [2:0] dec_dir;
  logic dec_enq, dec_dead, up_stall;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit pend = 0;
  int e_kind, e_dir, e_enq, e_dead, e_stall;
  string e_tag;

  always #2.5 clk = ~clk;

  eager_flit_checker #(.XW(XW), .YW(YW), .DEPTH(DEPTH), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst_x(in_dst_x), .in_dst_y(in_dst_y),
    .in_from(in_from), .in_eager(in_eager), .node_x(node_x), .node_y(node_y),
    .pref_on(pref_on), .pref_dir(pref_dir), .fifo_count(fifo_count),
    .dec_kind(dec_kind), .dec_dir(dec_dir), .dec_enq(dec_enq), .dec_dead(dec_dead),
    .up_stall(up_stall)
  );

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_pending();
    if (pend) begin
      chk({"R1 dir ", e_tag}, dec_dir, e_dir);
      chk({"kind ", e_tag}, dec_kind, e_kind);
      chk({"enq ", e_tag}, dec_enq, e_enq);
      chk({"dead ", e_tag}, dec_dead, e_dead);
      chk("R8 up_stall", up_stall, e_stall);
    end
  endtask

  task automatic drive(int v, int nx, int ny, int dx, int dy, int from, int eg,
                       int pon, int pd, int cnt);
    int ddx, ddy, rt, px, py, prog, dead;
    @(negedge clk);
    compare_pending();
    in_valid = v[0]; node_x = XW'(nx); node_y = YW'(ny);
    in_dst_x = XW'(dx); in_dst_y = YW'(dy); in_from = 3'(from);
    in_eager = eg[0]; pref_on = pon[0]; pref_dir = 3'(pd); fifo_count = CW'(cnt);
    ddx = dx - nx; ddy = dy - ny;
    rt = (ddx > 0) ? 2 : (ddx < 0) ? 4 : (ddy > 0) ? 1 : (ddy < 0) ? 3 : 0;
    px = nx; py = ny;
    case (from)
      1: py = ny + 1;
      2: px = nx + 1;
      3: py = ny - 1;
      4: px = nx - 1;
      default: ;
    endcase
    prog = (from == 0) || (iabs(dx - nx) < iabs(dx - px)) || (iabs(dy - ny) < iabs(dy - py));
    e_stall = (cnt >= DEPTH - 1) ? 1 : 0;
    if (v == 0) begin
      e_kind = 0; e_dir = 0; e_enq = 0; e_dead = 0; e_tag = "R10 idle";
    end else begin
      e_dir = rt;
      dead = (eg != 0 && prog == 0) ? 1 : 0;
      e_dead = dead;
      if (dead != 0) begin
        e_kind = (pon != 0) ? 1 : 3; e_enq = 0; e_tag = "R2 R3 R4 dead";
      end else if (eg != 0 && pon != 0 && pd == rt) begin
        e_kind = 1; e_enq = e_stall; e_tag = (e_stall != 0) ? "R9 pass+write" : "R5 pass";
      end else begin
        e_kind = 2; e_enq = 1; e_tag = "R6 enqueue";
      end
      if (ddx == 0 && ddy == 0) e_tag = {e_tag, " R7 home"};
    end
    pend = 1;
  endtask

  initial begin
    int xs[4] = '{0, 1, 3, 2};
    int ys[4] = '{0, 2, 3, 1};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset kind", dec_kind, 0);
    chk("R10 reset enq", dec_enq, 0);
    chk("R10 reset dead", dec_dead, 0);
    chk("R10 reset dir", dec_dir, 0);
    chk("R10 reset stall", up_stall, 0);
    rst_n = 1'b1;
    for (int n = 0; n < 4; n++)
      for (int d = 0; d < 16; d++)
        for (int f = 0; f < 5; f++)
          for (int e = 0; e < 2; e++)
            for (int p = 0; p < 2; p++)
              for (int pd = 0; pd < 5; pd++)
                for (int c = 0; c <= DEPTH; c++)
                  drive(1, xs[n], ys[n], d % 4, d / 4, f, e, p, pd, c);
    for (int i = 0; i < 48; i++)
      drive(0, i % 4, (i / 4) % 4, (i + 1) % 4, i % 3, i % 5, 1, i % 2, i % 5, i % 3);
    @(negedge clk);
    compare_pending();
    pend = 0;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule